// File: doc/BRIEF.md
# Satellite Control Tone Message Transmitter

This block keys a 22 kHz carrier on a single output line so that a host can send command messages to satellite dish equipment such as switches and positioners. The host presents up to `MAX_BYTES` command bytes, a byte count and a trailing burst choice, then pulses a start strobe. The block frames the message with two carrier-off gaps. Each byte goes out as nine pulse-width-coded bit slots: eight data bits and an odd parity bit. The block can then append a short burst and a settle pause, and it reports completion with a one-cycle done pulse.

All intervals are counted in ticks of 0.5 ms, produced by a prescaler from the system clock. A second divider makes the carrier square wave. When no transaction is running, a steady-tone input switches the carrier on or off continuously. The keying envelope is available on its own output next to the modulated line.

Top module: `dsq_tx`

## Requirements
- R1: A bit slot lasts 3 ticks, where one tick is `TICK_CYC` clock cycles. A 1 bit keys the carrier on for 1 tick and then off for 2 ticks. A 0 bit keys it on for 2 ticks and then off for 1 tick.
- R2: The bytes go out in order: byte 0 is `msg_i[7:0]`, byte 1 is `msg_i[15:8]`, and so on. Each byte is sent most significant bit first. After the eight data bits comes a parity bit equal to 1 XOR all eight data bits.
- R3: The transaction starts with 32 ticks of carrier off, beginning at the clock edge that accepts the start. The last byte is followed by another 32 ticks of carrier off.
- R4: A count of 0 sends no bytes, so the two gaps run back to back. A count above `MAX_BYTES` is treated as `MAX_BYTES`.
- R5: `burst_i` uses these codes: 0 means no burst, 3 is treated the same as 0, 1 sends the byte 0xFF with the bit coding and parity of R1 and R2, and 2 keys the carrier on for 25 ticks without a break.
- R6: After a burst, the carrier stays off for 40 ticks before the transaction ends. With no burst, the transaction ends when the second gap ends.
- R7: When idle, `key_o` follows `tone_en_i`. While busy, `tone_en_i` has no effect on `key_o`.
- R8: `line_o` is 0 whenever `key_o` is 0. While `key_o` stays high, `line_o` is a square wave that starts high and toggles every `TONE_HALF` cycles.
- R9: A start is accepted only while idle. `busy_o` is high from the accepting edge until the transaction ends. At that same edge `done_o` rises for exactly one cycle. Starts given while busy are ignored.
- R10: After reset the block is idle: `busy_o` and `done_o` are 0, and with `tone_en_i` at 0, `key_o` and `line_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| len_i | input | LEN_W | Number of command bytes |
| burst_i | input | 2 | Trailing burst code (R5) |
| msg_i | input | MAX_BYTES*8 | Command bytes, byte 0 in the low bits |
| tone_en_i | input | 1 | Steady carrier request while idle |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| key_o | output | 1 | Carrier keying envelope |
| line_o | output | 1 | Modulated carrier line |

## Verification
Directed messages cover these cases:
- A single byte with mixed bits, which separates the 1 and 0 slot shapes and makes the parity visible.
- Zero length with each burst code, which isolates the gap, data-burst, tone-burst and settle timing.
- An over-long count, which shows the clipping.
- The reserved burst code, which must behave like no burst.

Random messages of random length and burst are compared tick by tick against an envelope built in the bench. During these runs, stray start strobes and toggling of the steady-tone input show that neither one disturbs a running transaction. A free-running monitor follows the carrier phase across every keyed run, including idle steady tone.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    BURST_NONE = 2'd0,
    BURST_DATA = 2'd1,
    BURST_TONE = 2'd2,
    BURST_RSVD = 2'd3
  } burst_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ON,
    S_OFF,
    S_POST,
    S_TONE,
    S_SETTLE
  } seq_e;

  // odd parity: seed of one folded with every data bit
  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction

  // slot index 0..7 are data bits MSB first, index 8 is parity
  function automatic logic frame_bit(input logic [7:0] b, input logic [3:0] idx);
    logic [8:0] frame;
    frame = {b, odd_parity(b)};
    return frame[4'd8 - idx];
  endfunction

  // ticks of carrier-on for a bit value
  function automatic logic [1:0] on_ticks(input logic v);
    return v ? 2'd1 : 2'd2;
  endfunction

  // ticks of carrier-off for a bit value
  function automatic logic [1:0] off_ticks(input logic v);
    return v ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dsq_tick_gen.sv
module dsq_tick_gen #(
  parameter int TICK_CYC = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(TICK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(TICK_CYC - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dsq_carrier_gen.sv
module dsq_carrier_gen #(
  parameter int TONE_HALF = 2841
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_i,
  output logic line_o
);
  localparam int CW = $clog2(TONE_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!key_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == CW'(TONE_HALF - 1)) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign line_o = key_i & phase_q;
endmodule

// File: rtl/dsq_msg_store.sv
module dsq_msg_store #(
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [MAX_BYTES*8-1:0] msg_i,
  input  logic [LEN_W-1:0]       idx_i,
  output logic [7:0]             byte_o,
  output logic [LEN_W-1:0]       len_o
);
  logic [7:0]       bytes_q [MAX_BYTES];
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_i > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : len_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (load_i) len_q <= len_eff;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bytes_q[g] <= '0;
      else if (load_i) bytes_q[g] <= msg_i[g*8 +: 8];
    end
  end

  always_comb begin
    byte_o = '0;
    for (int g = 0; g < MAX_BYTES; g++) begin
      if (idx_i == LEN_W'(g)) byte_o = bytes_q[g];
    end
  end

  assign len_o = len_q;
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int LEN_W        = 4,
  parameter int GAP_TICKS    = 32,
  parameter int BURST_TICKS  = 25,
  parameter int SETTLE_TICKS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       burst_i,
  input  logic [7:0]       byte_i,
  input  logic             tick_i,
  output logic             accept_o,
  output logic [LEN_W-1:0] byte_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             key_o,
  output logic             gap_o,
  output logic             settle_o
);
  localparam int MAXT_A = (GAP_TICKS > BURST_TICKS) ? GAP_TICKS : BURST_TICKS;
  localparam int MAXT   = (MAXT_A > SETTLE_TICKS) ? MAXT_A : SETTLE_TICKS;
  localparam int CW     = $clog2(MAXT + 1);

  seq_e             state_q;
  burst_e           burst_q;
  logic [CW-1:0]    ivl_q;
  logic [3:0]       bit_idx_q;
  logic [LEN_W-1:0] byte_idx_q;
  logic             in_burst_q;
  logic             done_q;

  logic [7:0]    cur_byte;
  logic          cur_bit;
  logic [CW-1:0] target;
  logic          last;
  logic          last_bit;
  logic          last_byte;

  assign accept_o  = start_i && (state_q == S_IDLE);
  assign cur_byte  = in_burst_q ? 8'hFF : byte_i;
  assign cur_bit   = frame_bit(cur_byte, bit_idx_q);
  assign last_bit  = (bit_idx_q == 4'd8);
  assign last_byte = (byte_idx_q == len_i - 1'b1);

  always_comb begin
    case (state_q)
      S_PRE, S_POST: target = CW'(GAP_TICKS);
      S_ON:          target = CW'(on_ticks(cur_bit));
      S_OFF:         target = CW'(off_ticks(cur_bit));
      S_TONE:        target = CW'(BURST_TICKS);
      S_SETTLE:      target = CW'(SETTLE_TICKS);
      default:       target = CW'(1);
    endcase
  end

  assign last = tick_i && (ivl_q == target - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      burst_q    <= BURST_NONE;
      ivl_q      <= '0;
      bit_idx_q  <= '0;
      byte_idx_q <= '0;
      in_burst_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q    <= S_PRE;
        burst_q    <= burst_e'(burst_i);
        ivl_q      <= '0;
        bit_idx_q  <= '0;
        byte_idx_q <= '0;
        in_burst_q <= 1'b0;
      end else if (state_q != S_IDLE) begin
        if (!last) begin
          if (tick_i) ivl_q <= ivl_q + 1'b1;
        end else begin
          ivl_q <= '0;
          case (state_q)
            S_PRE: begin
              state_q <= (len_i == '0) ? S_POST : S_ON;
            end
            S_ON: state_q <= S_OFF;
            S_OFF: begin
              if (!last_bit) begin
                bit_idx_q <= bit_idx_q + 1'b1;
                state_q   <= S_ON;
              end else if (in_burst_q) begin
                state_q <= S_SETTLE;
              end else if (last_byte) begin
                state_q <= S_POST;
              end else begin
                bit_idx_q  <= '0;
                byte_idx_q <= byte_idx_q + 1'b1;
                state_q    <= S_ON;
              end
            end
            S_POST: begin
              case (burst_q)
                BURST_DATA: begin
                  in_burst_q <= 1'b1;
                  bit_idx_q  <= '0;
                  state_q    <= S_ON;
                end
                BURST_TONE: state_q <= S_TONE;
                default: begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                end
              endcase
            end
            S_TONE: state_q <= S_SETTLE;
            default: begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign byte_idx_o = byte_idx_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign key_o      = (state_q == S_ON) || (state_q == S_TONE);
  assign gap_o      = (state_q == S_PRE) || (state_q == S_POST);
  assign settle_o   = (state_q == S_SETTLE);
endmodule

// File: rtl/dsq_tx.sv
module dsq_tx #(
  parameter int MAX_BYTES    = 6,
  parameter int LEN_W        = 4,
  parameter int TICK_CYC     = 62500,
  parameter int TONE_HALF    = 2841,
  parameter int GAP_TICKS    = 32,
  parameter int BURST_TICKS  = 25,
  parameter int SETTLE_TICKS = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [1:0]             burst_i,
  input  logic [MAX_BYTES*8-1:0] msg_i,
  input  logic                   tone_en_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   key_o,
  output logic                   line_o
);
  logic             accept_w;
  logic             tick_w;
  logic [LEN_W-1:0] byte_idx_w;
  logic [LEN_W-1:0] len_w;
  logic [7:0]       byte_w;
  logic             seq_key_w;
  logic             gap_w;
  logic             settle_w;

  dsq_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(accept_w), .tick_o(tick_w)
  );

  dsq_msg_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .len_i(len_i), .msg_i(msg_i),
    .idx_i(byte_idx_w), .byte_o(byte_w), .len_o(len_w)
  );

  dsq_sequencer #(
    .LEN_W(LEN_W), .GAP_TICKS(GAP_TICKS),
    .BURST_TICKS(BURST_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_w), .burst_i(burst_i),
    .byte_i(byte_w), .tick_i(tick_w), .accept_o(accept_w), .byte_idx_o(byte_idx_w),
    .busy_o(busy_o), .done_o(done_o), .key_o(seq_key_w), .gap_o(gap_w),
    .settle_o(settle_w)
  );

  // a running transaction owns the carrier; idle follows the steady request
  assign key_o = busy_o ? seq_key_w : tone_en_i;

  dsq_carrier_gen #(.TONE_HALF(TONE_HALF)) u_car (
    .clk(clk), .rst_n(rst_n), .key_i(key_o), .line_o(line_o)
  );
endmodule

// File: rtl/dsq_tx_chk.sv
module dsq_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic key_o,
  input logic line_o,
  input logic gap_w,
  input logic settle_w
);
  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R3
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_w |-> !key_o);
  // R6
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_w |-> !key_o);
  // R8
  line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_o |-> !line_o);
endmodule

bind dsq_tx dsq_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .key_o(key_o), .line_o(line_o), .gap_w(gap_w), .settle_w(settle_w)
);

// File: tb/tb_dsq_tx.sv
module tb_dsq_tx;
  localparam int MAXB = 6, LW = 4, TICK = 8, HALF = 3;
  localparam int GAP = 32, TB = 25, SET = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start_i = 1'b0;
  logic [LW-1:0]     len_i = '0;
  logic [1:0]        burst_i = '0;
  logic [MAXB*8-1:0] msg_i = '0;
  logic              tone_en_i = 1'b0;
  wire busy_o, done_o, key_o, line_o;

  dsq_tx #(.MAX_BYTES(MAXB), .LEN_W(LW), .TICK_CYC(TICK), .TONE_HALF(HALF),
           .GAP_TICKS(GAP), .BURST_TICKS(TB), .SETTLE_TICKS(SET)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .burst_i(burst_i),
    .msg_i(msg_i), .tone_en_i(tone_en_i), .busy_o(busy_o), .done_o(done_o),
    .key_o(key_o), .line_o(line_o));

  int errs = 0, checks = 0;
  bit exp_env [4096];
  int n_exp;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // envelope model in ticks
  task automatic add_seg(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin exp_env[n_exp] = lvl; n_exp++; end
  endtask
  task automatic add_bit(input bit v);
    if (v) begin add_seg(1, 1); add_seg(0, 2); end
    else   begin add_seg(1, 2); add_seg(0, 1); end
  endtask
  task automatic add_byte(input logic [7:0] b);
    bit p = 1'b1;
    for (int i = 7; i >= 0; i--) begin p = p ^ b[i]; add_bit(b[i]); end
    add_bit(p);
  endtask
  task automatic build(input int len, input int burst, input logic [MAXB*8-1:0] m);
    int eff;
    n_exp = 0;
    eff = (len > MAXB) ? MAXB : len;
    add_seg(0, GAP);
    for (int j = 0; j < eff; j++) add_byte(m[j*8 +: 8]);
    add_seg(0, GAP);
    if (burst == 1) begin add_byte(8'hFF); add_seg(0, SET); end
    else if (burst == 2) begin add_seg(1, TB); add_seg(0, SET); end
  endtask

  // carrier phase monitor (R8)
  bit mon_on = 0;
  int run = 0, car_err = 0, car_first_act = 0, car_first_exp = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      bit e;
      e = key_o ? !((run / HALF) % 2) : 1'b0;
      if (line_o !== e) begin
        if (car_err == 0) begin car_first_act = line_o; car_first_exp = e; end
        car_err++;
      end
      run = key_o ? run + 1 : 0;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic run_tx(input int len, input int burst, input logic [MAXB*8-1:0] m,
                        input bit noise, input string tag);
    int total, env_bad, busy_bad, done_bad, first_k;
    build(len, burst, m);
    total = n_exp * TICK;
    env_bad = 0; busy_bad = 0; done_bad = 0; first_k = -1;
    @(negedge clk);
    len_i = LW'(len); burst_i = 2'(burst); msg_i = m; start_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      start_i = 1'b0;
      if (key_o !== exp_env[k / TICK]) begin
        env_bad++;
        if (first_k < 0) first_k = k;
      end
      if (busy_o !== 1'b1) busy_bad++;
      if (done_o !== 1'b0) done_bad++;
      if (noise) begin
        if (($urandom % 16) == 0) tone_en_i = ~tone_en_i;
        if (k < total - 3 && ($urandom % 32) == 0) begin
          start_i = 1'b1;
          len_i = LW'($urandom);
          burst_i = 2'($urandom);
          msg_i = {$urandom, $urandom};
        end
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(env_bad == 0, {tag, " envelope mismatch cycles (first at ", $sformatf("%0d", first_k), ")"},
          env_bad, 0);
    check(busy_bad == 0, "R9 busy low during transaction", busy_bad, 0);
    check(done_bad == 0, "R9 done early", done_bad, 0);
    check(busy_o == 1'b0 && done_o == 1'b1, "R9 end: busy/done", {busy_o, done_o}, 1);
    check(key_o == tone_en_i, "R7 idle key after end", key_o, tone_en_i);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done single cycle", done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy_o == 0 && done_o == 0, "R10 busy/done in reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R10 busy/done after reset", {busy_o, done_o}, 0);
    check(key_o == 0 && line_o == 0, "R10 key/line after reset", {key_o, line_o}, 0);
    mon_on = 1;

    // R7 steady tone while idle
    tone_en_i = 1'b1;
    repeat (20) @(negedge clk);
    check(key_o == 1'b1, "R7 steady tone on", key_o, 1);
    tone_en_i = 1'b0;
    @(negedge clk);
    check(key_o == 1'b0 && line_o == 1'b0, "R7 steady tone off", {key_o, line_o}, 0);

    // directed cases
    run_tx(1, 0, 48'h0000_0000_00A5, 0, "R1 R2 R3 R6 single byte");
    run_tx(2, 0, 48'h0000_0000_3C81, 0, "R2 byte order");
    run_tx(0, 0, '0, 0, "R4 zero length");
    run_tx(0, 1, '0, 0, "R5 R6 data burst");
    run_tx(0, 2, '0, 0, "R5 R6 tone burst");
    run_tx(2, 3, 48'h0000_0000_F00F, 0, "R5 reserved burst code");
    run_tx(15, 0, 48'h1122_3344_5566, 0, "R4 clipped length");
    run_tx(6, 2, 48'hFFFF_0000_FF00, 0, "R2 full buffer");
    tone_en_i = 1'b1;
    run_tx(1, 1, 48'h0000_0000_0001, 0, "R7 tone request ignored while busy");
    tone_en_i = 1'b0;

    // random transactions with stray starts and tone toggling
    for (int t = 0; t < 20; t++) begin
      run_tx(int'($urandom % 9), int'($urandom % 4), {$urandom, $urandom}, 1,
             "R1 R2 R4 R5 R7 R9 random");
    end

    tone_en_i = 1'b1;
    repeat (30) @(negedge clk);
    tone_en_i = 1'b0;
    repeat (3) @(negedge clk);
    check(car_err == 0, "R8 carrier phase mismatch count", car_err, 0);
    if (car_err != 0)
      $display("  first carrier mismatch line=%0d vs %0d", car_first_act, car_first_exp);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule